// File: doc/BRIEF.md
# Four-Phase Oversampled Edge Timestamper

This block finds out in which quarter of a reference clock period the rising edge of an asynchronous input pulse arrived. Four clocks of the same frequency, spaced 90 degrees apart, each sample the input in their own edge-triggered flops. Each clock period is therefore split into four sampling slots, and the time resolution is a quarter period. The pulse must be wider than that quarter for at least one phase to see it.

The 180 and 270 degree samples are first re-registered on the 90 degree clock. All four samples are then brought onto the 0 degree reference clock and lined up so that they describe the same period. The decision is made only in that single domain. The block looks for a low-to-high step between successive samples, and not for a high level, because every phase sees a long pulse high in the end. It reports the earliest phase that saw the step. An edge that falls after the 270 degree sample and before the next 0 degree sample counts as phase 0 of the next period.

Each edge produces a one-cycle strobe and a two-bit phase index. A wrapping 8-bit counter for each phase counts how often that phase was reported first. After a report, the block waits until one full period has been sampled low in every phase before it accepts another edge.

Top module: `quad_phase_edge_stamper`

## Requirements
- R1: A rising edge that arrives after the sampling edge of phase p-1 and at or before the sampling edge of phase p, with p in 1..3, is reported with `hit_phase` = p. Index 0 means 0°, 1 means 90°, 2 means 180° and 3 means 270°.
- R2: A rising edge that arrives after the 270° sample of one period and before the 0° sample of the next period is reported as phase 0 of the later period.
- R3: When several phases, or all of them, see the pulse high, only one report is made, and it names the earliest phase that saw the low-to-high step.
- R4: `hit_valid` is high for exactly one `clk0` cycle for each reported edge.
- R5: Let k be the reference period, starting at a `clk0` rising edge, that holds the first high sample. `hit_valid` rises on the third `clk0` rising edge after the start of period k.
- R6: After a report, any further rising edge is ignored until one period has been sampled low in all four phases. A brief low dip that only some phases catch does not allow a second report.
- R7: The counter for phase i is `hit_count[8*i+7:8*i]`. It increments on the same `clk0` edge on which `hit_valid` rises with `hit_phase` = i. The counters of the other phases stay unchanged.
- R8: Each per-phase counter wraps from 255 to 0.
- R9: `rst` is synchronous, active-high and clocked by `clk0`. It clears `hit_valid`, `hit_phase` and all counters. After reset is released, no report is made until the input has been sampled low in all four phases, even if the input was high throughout reset.
- R10: A pulse only slightly wider than a quarter period, caught high by a single phase, is reported with that phase's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Reference clock, 0° phase |
| clk90 | input | 1 | Sampling clock shifted 90° |
| clk180 | input | 1 | Sampling clock shifted 180° |
| clk270 | input | 1 | Sampling clock shifted 270° |
| rst | input | 1 | Synchronous active-high reset in the clk0 domain |
| pulse_in | input | 1 | Asynchronous pulse input |
| hit_valid | output | 1 | One-cycle strobe for each reported edge |
| hit_phase | output | 2 | Index of the earliest phase that saw the edge |
| hit_count | output | 4*CNT_W | Per-phase report counters, phase i at bits [CNT_W*i +: CNT_W] |

## Verification
Two events can land in the same reference cycle: the strobe for a report and the wrap of that phase's counter from 255 to 0. The bench provokes this by sending 256 narrow pulses, each seen only by the 180° phase. It then judges that exactly 256 strobes appeared, all tagged phase 2, and that the phase 2 counter is back at its starting value while the other counters have not moved. The edge case where a pulse crosses the period boundary is also timed. It is checked against the next period's phase 0 and against a latency one cycle longer than the other phases.

// File: rtl/qpe_pkg.sv
`timescale 1ns/1ps
package qpe_pkg;
  localparam int NPH  = 4;            // 0, 90, 180, 270 degrees
  localparam int PH_W = $clog2(NPH);

  // Low-to-high steps in sample order: previous period's last sample, then phase 0..NPH-1
  function automatic logic [NPH-1:0] step_map(input logic last_prev, input logic [NPH-1:0] smp);
    logic [NPH-1:0] r;
    r[0] = smp[0] & ~last_prev;
    for (int i = 1; i < NPH; i++) r[i] = smp[i] & ~smp[i-1];
    return r;
  endfunction

  // Lowest set position = earliest phase
  function automatic logic [PH_W-1:0] earliest(input logic [NPH-1:0] r);
    logic [PH_W-1:0] idx;
    idx = '0;
    for (int i = NPH - 1; i >= 0; i--) if (r[i]) idx = PH_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/phase_sampler.sv
`timescale 1ns/1ps
module phase_sampler (
  input  logic clk,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) q <= d;
endmodule

// File: rtl/phase_retime.sv
`timescale 1ns/1ps
module phase_retime
  import qpe_pkg::*;
(
  input  logic           clk0,
  input  logic           clk90,
  input  logic           rst,
  input  logic [NPH-1:0] raw,
  output logic [NPH-1:0] aligned
);
  // first hop: late phases onto the 90 degree clock
  logic hop180, hop270;
  always_ff @(posedge clk90) begin
    hop180 <= raw[2];
    hop270 <= raw[3];
  end

  // second hop: everything onto clk0, early phases delayed one more cycle
  logic st0_a, st0_b, st90_a, st90_b, al180, al270;
  always_ff @(posedge clk0) begin
    if (rst) begin
      st0_a  <= 1'b0;
      st0_b  <= 1'b0;
      st90_a <= 1'b0;
      st90_b <= 1'b0;
      al180  <= 1'b0;
      al270  <= 1'b0;
    end else begin
      st0_a  <= raw[0];
      st0_b  <= st0_a;
      st90_a <= raw[1];
      st90_b <= st90_a;
      al180  <= hop180;
      al270  <= hop270;
    end
  end

  assign aligned = {al270, al180, st90_b, st0_b};
endmodule

// File: rtl/edge_judge.sv
`timescale 1ns/1ps
module edge_judge
  import qpe_pkg::*;
(
  input  logic            clk0,
  input  logic            rst,
  input  logic [NPH-1:0]  aligned,
  output logic            edge_found,
  output logic [PH_W-1:0] pick_idx,
  output logic            armed,
  output logic            hit_valid,
  output logic [PH_W-1:0] hit_phase
);
  localparam int WARM = 2;   // cycles until aligned carries real samples after reset

  logic            last_prev;
  logic [WARM-1:0] warm;
  logic [NPH-1:0]  steps;
  logic            all_low;

  assign steps      = step_map(last_prev, aligned);
  assign all_low    = ~|aligned;
  assign edge_found = armed & (|steps);
  assign pick_idx   = earliest(steps);

  always_ff @(posedge clk0) begin
    if (rst) begin
      last_prev <= 1'b0;
      warm      <= '0;
      armed     <= 1'b0;
      hit_valid <= 1'b0;
      hit_phase <= '0;
    end else begin
      last_prev <= aligned[NPH-1];
      warm      <= {warm[WARM-2:0], 1'b1};
      hit_valid <= edge_found;
      if (edge_found) begin
        hit_phase <= pick_idx;
        armed     <= 1'b0;
      end else if (all_low && warm[WARM-1]) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hit_counters.sv
`timescale 1ns/1ps
module hit_counters
  import qpe_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk0,
  input  logic                 rst,
  input  logic                 inc_en,
  input  logic [PH_W-1:0]      inc_idx,
  output logic [NPH*CNT_W-1:0] count
);
  for (genvar gi = 0; gi < NPH; gi++) begin : g_cnt
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk0) begin
      if (rst)                                  c <= '0;
      else if (inc_en && inc_idx == PH_W'(gi))  c <= c + 1'b1;
    end
    assign count[gi*CNT_W +: CNT_W] = c;
  end
endmodule

// File: rtl/quad_phase_edge_stamper.sv
`timescale 1ns/1ps
module quad_phase_edge_stamper
  import qpe_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk0,
  input  logic                 clk90,
  input  logic                 clk180,
  input  logic                 clk270,
  input  logic                 rst,
  input  logic                 pulse_in,
  output logic                 hit_valid,
  output logic [PH_W-1:0]      hit_phase,
  output logic [NPH*CNT_W-1:0] hit_count
);
  logic [NPH-1:0]  clk_v;
  logic [NPH-1:0]  raw;
  logic [NPH-1:0]  aligned;
  logic            edge_found;
  logic            armed;
  logic [PH_W-1:0] pick_idx;

  assign clk_v = {clk270, clk180, clk90, clk0};

  for (genvar gi = 0; gi < NPH; gi++) begin : g_smp
    phase_sampler u_smp (.clk(clk_v[gi]), .d(pulse_in), .q(raw[gi]));
  end

  phase_retime u_rt (
    .clk0(clk0), .clk90(clk90), .rst(rst), .raw(raw), .aligned(aligned)
  );

  edge_judge u_jd (
    .clk0(clk0), .rst(rst), .aligned(aligned),
    .edge_found(edge_found), .pick_idx(pick_idx), .armed(armed),
    .hit_valid(hit_valid), .hit_phase(hit_phase)
  );

  hit_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk0(clk0), .rst(rst), .inc_en(edge_found), .inc_idx(pick_idx),
    .count(hit_count)
  );
endmodule

// File: rtl/qpe_checker.sv
`timescale 1ns/1ps
module qpe_checker
  import qpe_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic                 clk0,
  input logic                 rst,
  input logic                 hit_valid,
  input logic [PH_W-1:0]      hit_phase,
  input logic [NPH*CNT_W-1:0] hit_count,
  input logic                 edge_found
);
  // R9
  reset_clear_chk: assert property (@(posedge clk0)
    rst |=> (!hit_valid && hit_count == '0));

  // R4
  strobe_single_chk: assert property (@(posedge clk0) disable iff (rst)
    hit_valid |=> !hit_valid);

  // R6
  report_armed_chk: assert property (@(posedge clk0) disable iff (rst)
    hit_valid |-> $past(edge_found));

  for (genvar gi = 0; gi < NPH; gi++) begin : g_chk
    // R7
    count_step_chk: assert property (@(posedge clk0) disable iff (rst)
      (hit_valid && hit_phase == PH_W'(gi)) |->
        hit_count[gi*CNT_W +: CNT_W] == CNT_W'($past(hit_count[gi*CNT_W +: CNT_W]) + 1));

    // R7
    count_hold_chk: assert property (@(posedge clk0) disable iff (rst)
      !(hit_valid && hit_phase == PH_W'(gi)) |-> $stable(hit_count[gi*CNT_W +: CNT_W]));
  end
endmodule

bind quad_phase_edge_stamper qpe_checker #(.CNT_W(CNT_W)) u_qpe_chk (
  .clk0(clk0), .rst(rst), .hit_valid(hit_valid), .hit_phase(hit_phase),
  .hit_count(hit_count), .edge_found(edge_found)
);

// File: tb/quad_phase_edge_stamper_test.sv
`timescale 1ns/1ps
module quad_phase_edge_stamper_test;
  localparam int CW = 8;

  int   ph = 0;
  logic clk0, clk90, clk180, clk270;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic       hit_valid;
  logic [1:0] hit_phase;
  logic [4*CW-1:0] hit_count;

  // 8 ns period (125 MHz); quarter slots start at 0, 2, 4, 6 ns
  initial forever #1 ph = ph + 1;
  assign clk0   = (ph % 8) < 4;
  assign clk90  = ((ph + 6) % 8) < 4;
  assign clk180 = ((ph + 4) % 8) < 4;
  assign clk270 = ((ph + 2) % 8) < 4;

  quad_phase_edge_stamper #(.CNT_W(CW)) uut (
    .clk0(clk0), .clk90(clk90), .clk180(clk180), .clk270(clk270),
    .rst(rst), .pulse_in(pulse_in),
    .hit_valid(hit_valid), .hit_phase(hit_phase), .hit_count(hit_count)
  );

  int  nchk = 0, nfail = 0;
  int  nval = 0;
  int  last_ph = 0;
  real last_t = 0.0;

  always @(negedge clk0) begin
    if (hit_valid) begin
      nval    = nval + 1;
      last_ph = int'(hit_phase);
      last_t  = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cnt_of(input int i);
    return int'(hit_count[i*CW +: CW]);
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (5) @(posedge clk0);
    #0.5 rst = 1'b0;
    repeat (6) @(posedge clk0);
    @(negedge clk0);
  endtask

  // rise placed just before phase p's sampling edge; p == 0 uses the next period's 0 edge
  function automatic real rise_ofs(input int p);
    return (p == 0) ? 6.5 : 2.0 * p - 1.5;
  endfunction

  task automatic single_pulse(input int p, input real width, input string req);
    int  n0;
    int  c0[4];
    real t0;
    n0 = nval;
    for (int i = 0; i < 4; i++) c0[i] = cnt_of(i);
    @(posedge clk0);
    t0 = $realtime;
    #(rise_ofs(p)) pulse_in = 1'b1;
    #(width) pulse_in = 1'b0;
    repeat (14) @(posedge clk0);
    @(negedge clk0);
    check(nval - n0 == 1, "R4", "reports per pulse", nval - n0, 1);
    check(last_ph == p, req, "phase index", last_ph, p);
    check(last_t == t0 + 8.0 * ((p == 0) ? 4 : 3) + 4.0, "R5", "strobe time ns",
          int'(last_t), int'(t0 + 8.0 * ((p == 0) ? 4 : 3) + 4.0));
    for (int i = 0; i < 4; i++)
      check(cnt_of(i) == ((c0[i] + ((i == p) ? 1 : 0)) % 256), "R7", $sformatf("count phase %0d", i),
            cnt_of(i), (c0[i] + ((i == p) ? 1 : 0)) % 256);
  endtask

  task automatic long_pulse();
    int n0;
    n0 = nval;
    @(posedge clk0);
    #(rise_ofs(1)) pulse_in = 1'b1;
    #200 pulse_in = 1'b0;
    repeat (14) @(posedge clk0);
    @(negedge clk0);
    check(nval - n0 == 1, "R3", "reports for long pulse", nval - n0, 1);
    check(last_ph == 1, "R3", "earliest phase", last_ph, 1);
  endtask

  task automatic glitch_pulse();
    int n0;
    int c1;
    n0 = nval;
    c1 = cnt_of(1);
    @(posedge clk0);
    #(rise_ofs(1)) pulse_in = 1'b1;
    #20 pulse_in = 1'b0;
    #3  pulse_in = 1'b1;
    #20 pulse_in = 1'b0;
    repeat (14) @(posedge clk0);
    @(negedge clk0);
    check(nval - n0 == 1, "R6", "reports with short dip", nval - n0, 1);
    check(cnt_of(1) == (c1 + 1) % 256, "R6", "count phase 1", cnt_of(1), (c1 + 1) % 256);
  endtask

  task automatic two_pulses();
    int n0;
    int c3;
    n0 = nval;
    c3 = cnt_of(3);
    @(posedge clk0);
    #(rise_ofs(3)) pulse_in = 1'b1;
    #20 pulse_in = 1'b0;
    #60 pulse_in = 1'b1;
    #20 pulse_in = 1'b0;
    repeat (14) @(posedge clk0);
    @(negedge clk0);
    check(nval - n0 == 2, "R6", "reports for separated pulses", nval - n0, 2);
    check(cnt_of(3) == (c3 + 2) % 256, "R7", "count phase 3", cnt_of(3), (c3 + 2) % 256);
  endtask

  task automatic wrap_run();
    int n0;
    int c[4];
    int bad_ph;
    n0 = nval;
    bad_ph = 0;
    for (int i = 0; i < 4; i++) c[i] = cnt_of(i);
    for (int k = 0; k < 256; k++) begin
      @(posedge clk0);
      #(rise_ofs(2)) pulse_in = 1'b1;
      #3 pulse_in = 1'b0;
      repeat (3) @(posedge clk0);
      @(negedge clk0);
      if (hit_valid && hit_phase != 2'd2) bad_ph++;
    end
    repeat (8) @(posedge clk0);
    @(negedge clk0);
    check(nval - n0 == 256, "R8", "reports in wrap run", nval - n0, 256);
    check(last_ph == 2 && bad_ph == 0, "R10", "narrow pulse phase", last_ph, 2);
    for (int i = 0; i < 4; i++)
      check(cnt_of(i) == c[i], "R8", $sformatf("count phase %0d after 256", i), cnt_of(i), c[i]);
  endtask

  task automatic reset_high();
    int n0;
    pulse_in = 1'b1;
    do_reset();
    n0 = nval;
    check(!hit_valid, "R9", "valid after reset", int'(hit_valid), 0);
    check(hit_count == '0, "R9", "counters after reset", int'(hit_count), 0);
    repeat (10) @(posedge clk0);
    @(negedge clk0);
    check(nval == n0, "R9", "reports while held high", nval - n0, 0);
    pulse_in = 1'b0;
    repeat (6) @(posedge clk0);
    single_pulse(2, 20.0, "R9");
  endtask

  initial begin
    #400000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    do_reset();
    check(!hit_valid, "R9", "valid in reset state", int'(hit_valid), 0);
    check(hit_count == '0, "R9", "counters in reset state", int'(hit_count), 0);
    check(nval == 0, "R9", "strobes since start", nval, 0);
    single_pulse(1, 20.0, "R1");
    single_pulse(2, 20.0, "R1");
    single_pulse(3, 20.0, "R1");
    single_pulse(0, 20.0, "R2");
    single_pulse(1, 3.0, "R10");
    single_pulse(0, 3.0, "R2");
    long_pulse();
    glitch_pulse();
    two_pulses();
    wrap_run();
    reset_high();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule